// File: doc/BRIEF.md
# Two-Key Register Write-Protection Lock

This block keeps a small bank of configuration registers safe from stray writes. After reset the bank is locked, and every write to a protected register is discarded. To open it, software writes a first 32-bit key to one kick address and then a second 32-bit key to another kick address. After a short, fixed settling delay the block becomes unlocked, and from then on protected writes take effect.

The lock state can be read back as a status bit in the control register, so software polls that bit after it has written both keys. A wrong key, or the keys in the wrong order, sends the sequence back to its start. While the block is unlocked, any value other than the first key written to the first kick address locks it again. The kick addresses always read as zero, so the keys cannot be read back.

Top module: `wprot_lock`

## Requirements
- R1: On reset the block is locked. The status bit is 0, and every protected register and control register bit is cleared to 0.
- R2: While the block is not unlocked, including the settling delay, writes to protected registers (offsets 0x00, 0x04, 0x08, 0x0C) and to the control register (0x50) leave their contents unchanged.
- R3: Writing 0x83E70B13 to offset 0x70 and then 0x95A4F1E0 to offset 0x74 unlocks the block. Bit 23 of the control register at 0x50 then reads 1.
- R4: The status bit rises exactly UNLOCK_LAT clock edges after the edge that accepts the second key, and reads 0 until then.
- R5: A write to 0x74 without a preceding valid first key does not start an unlock. A wrong value at 0x74 after a valid first key returns the sequence to idle, so a later correct second key alone does not unlock.
- R6: A wrong value at 0x70 after a valid first key returns the sequence to idle.
- R7: While the block is unlocked or settling, any value other than 0x83E70B13 written to 0x70 locks it. Writing 0x83E70B13 to 0x70 again, or any value to 0x74, leaves the state unchanged.
- R8: Reads from 0x70 and 0x74 always return 0.
- R9: While the block is unlocked, writes to protected registers take effect and read back. In the control register all bits except bit 23 are writable; bit 23 ignores writes and always shows the lock status.
- R10: Writes to other addresses between the first and the second key do not break the sequence, and they are still discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| unlocked | output | 1 | Lock status, 1 when protected writes are accepted |

## Verification
The assertions assume that wr_en is a clean single-cycle strobe, with addr and wdata stable around the capturing edge, and that reset is held for at least one edge before any access. The bench drives every input on the falling edge, keeps wr_en high for exactly one rising edge per write, and reads only combinationally between edges, so these assumptions always hold. The wait before each status read is counted in edges from the one that accepts the second key, so the settling delay is checked at its exact boundary.

// File: rtl/wprot_pkg.sv
`timescale 1ns/1ps
// Package wprot_pkg
// Shared constants and types for the write-protection lock.
// Assumes byte offsets of at least 8 bits and 32-bit data.
package wprot_pkg;
    localparam int          DATA_W      = 32;
    localparam logic [7:0]  KICK_A_OFS  = 8'h70;
    localparam logic [7:0]  KICK_B_OFS  = 8'h74;
    localparam logic [7:0]  CTL_OFS     = 8'h50;
    localparam logic [31:0] KEY_A       = 32'h83E7_0B13;
    localparam logic [31:0] KEY_B       = 32'h95A4_F1E0;
    localparam int          STATUS_BIT  = 23;

    typedef enum logic [1:0] {
        LK_IDLE  = 2'd0,
        LK_ARMED = 2'd1,
        LK_PEND  = 2'd2,
        LK_OPEN  = 2'd3
    } lk_state_t;
endpackage

// File: rtl/wprot_key_fsm.sv
`timescale 1ns/1ps
// Module wprot_key_fsm
// Watches writes to the two kick offsets and tracks the lock state.
// The first key arms it, the second key starts a settling count of
// UNLOCK_LAT edges, after which the state is open. A bad first-kick
// value always falls back to idle (locked).
// Assumes UNLOCK_LAT >= 1 and wr_en asserted for one edge per write.
module wprot_key_fsm
    import wprot_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int UNLOCK_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output lk_state_t         state_o,
    output logic              unlocked_o
);
    localparam int CNT_W = $clog2(UNLOCK_LAT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(UNLOCK_LAT - 1);

    lk_state_t        state_q, state_n;
    logic [CNT_W-1:0] cnt_q;
    logic             hit_a, hit_b, good_a, good_b;

    // Decode kick writes and key matches.
    always_comb begin
        hit_a  = wr_en && (addr == ADDR_W'(KICK_A_OFS));
        hit_b  = wr_en && (addr == ADDR_W'(KICK_B_OFS));
        good_a = (wdata == KEY_A);
        good_b = (wdata == KEY_B);
    end

    // Next-state selection for the key sequence.
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            LK_IDLE: begin
                if (hit_a && good_a) state_n = LK_ARMED;
            end
            LK_ARMED: begin
                if (hit_a)      state_n = good_a ? LK_ARMED : LK_IDLE;
                else if (hit_b) state_n = good_b ? LK_PEND  : LK_IDLE;
            end
            LK_PEND: begin
                if (hit_a && !good_a)      state_n = LK_IDLE;
                else if (cnt_q == CNT_LAST) state_n = LK_OPEN;
            end
            LK_OPEN: begin
                if (hit_a && !good_a) state_n = LK_IDLE;
            end
            default: state_n = LK_IDLE;
        endcase
    end

    // State register with synchronous reset to locked.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_IDLE;
        else        state_q <= state_n;
    end

    // Settling counter, runs only while staying in the pending state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (state_q == LK_PEND && state_n == LK_PEND)
            cnt_q <= cnt_q + 1'b1;
        else
            cnt_q <= '0;
    end

    assign state_o    = state_q;
    assign unlocked_o = (state_q == LK_OPEN);

    AST_RESET_LOCKED: assert property (@(posedge clk)
        !rst_n |=> (state_q == LK_IDLE));                           // R1
    AST_OPEN_AFTER_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked_o) |-> ($past(state_q) == LK_PEND));          // R4
    AST_PEND_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_PEND) |-> (cnt_q < CNT_W'(UNLOCK_LAT)));       // R4
    AST_BAD_KEY_A_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_a && !good_a) |=> !unlocked_o);                          // R7
    AST_KICK_B_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == LK_IDLE) && hit_b) |=> (state_q != LK_PEND));    // R5
endmodule

// File: rtl/wprot_wr_gate.sv
`timescale 1ns/1ps
// Module wprot_wr_gate
// Decodes write offsets into per-register write enables and blocks
// all of them unless the lock is open.
// Assumes protected registers sit at PROT_BASE + 4*i, word aligned.
module wprot_wr_gate
    import wprot_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_PROT  = 4,
    parameter int PROT_BASE = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                unlocked,
    output logic [NUM_PROT-1:0] prot_we,
    output logic                ctl_we
);
    logic allow;

    // Writes pass only while open.
    assign allow  = wr_en && unlocked;
    assign ctl_we = allow && (addr == ADDR_W'(CTL_OFS));

    // One decoder per protected register.
    for (genvar gi = 0; gi < NUM_PROT; gi++) begin : g_dec
        assign prot_we[gi] = allow && (addr == ADDR_W'(PROT_BASE + 4 * gi));
    end

    AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prot_we, ctl_we}));                                 // R9
    AST_NO_WE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |-> ({prot_we, ctl_we} == '0));                     // R2
endmodule

// File: rtl/wprot_bank.sv
`timescale 1ns/1ps
// Module wprot_bank
// Storage for the protected registers and the control register.
// The status bit position of the control register is never stored.
// Assumes write enables arrive already gated by the lock.
module wprot_bank
    import wprot_pkg::*;
#(
    parameter int NUM_PROT = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_PROT-1:0]             prot_we,
    input  logic                            ctl_we,
    input  logic [DATA_W-1:0]               wdata,
    output logic [NUM_PROT-1:0][DATA_W-1:0] bank_q,
    output logic [DATA_W-1:0]               ctl_q
);
    localparam logic [DATA_W-1:0] CTL_MASK = ~(DATA_W'(1) << STATUS_BIT);

    // One register per protected word.
    for (genvar gi = 0; gi < NUM_PROT; gi++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)           bank_q[gi] <= '0;
            else if (prot_we[gi]) bank_q[gi] <= wdata;
        end
    end

    // Control register, status position held at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_we) ctl_q <= wdata & CTL_MASK;
    end

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_we == '0) |=> $stable(bank_q));                          // R2
    AST_CTL_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[STATUS_BIT]);                                           // R9
endmodule

// File: rtl/wprot_lock.sv
`timescale 1ns/1ps
// Module wprot_lock
// Top of the write-protection lock: key sequence, write gating,
// protected storage and the read multiplexer.
// Assumes a one-edge write strobe and combinational reads.
module wprot_lock
    import wprot_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int NUM_PROT   = 4,
    parameter int PROT_BASE  = 0,
    parameter int UNLOCK_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              unlocked
);
    lk_state_t                       state;
    logic [NUM_PROT-1:0]             prot_we;
    logic                            ctl_we;
    logic [NUM_PROT-1:0][DATA_W-1:0] bank_q;
    logic [DATA_W-1:0]               ctl_q;

    wprot_key_fsm #(.ADDR_W(ADDR_W), .UNLOCK_LAT(UNLOCK_LAT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .state_o(state), .unlocked_o(unlocked)
    );

    wprot_wr_gate #(.ADDR_W(ADDR_W), .NUM_PROT(NUM_PROT),
                    .PROT_BASE(PROT_BASE)) u_gate (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .unlocked(unlocked), .prot_we(prot_we), .ctl_we(ctl_we)
    );

    wprot_bank #(.NUM_PROT(NUM_PROT)) u_bank (
        .clk(clk), .rst_n(rst_n), .prot_we(prot_we), .ctl_we(ctl_we),
        .wdata(wdata), .bank_q(bank_q), .ctl_q(ctl_q)
    );

    // Read multiplexer; kick offsets fall to the zero default.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(CTL_OFS)) begin
            rdata = ctl_q;
            rdata[STATUS_BIT] = unlocked;
        end
        for (int i = 0; i < NUM_PROT; i++) begin
            if (addr == ADDR_W'(PROT_BASE + 4 * i)) rdata = bank_q[i];
        end
    end

    AST_KICK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr == ADDR_W'(KICK_A_OFS)) || (addr == ADDR_W'(KICK_B_OFS)))
        |-> (rdata == '0));                                            // R8
    AST_LOCKED_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && wr_en) |=> ($stable(bank_q) && $stable(ctl_q)));  // R2
    AST_STATUS_MATCHES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_PEND) |-> !unlocked);                             // R4
endmodule

// File: tb/test_wprot_lock.sv
`timescale 1ns/1ps
module test_wprot_lock;
    localparam int LAT = 4;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_ID = 2'd2;
    localparam logic [31:0] KA = 32'h83E7_0B13;
    localparam logic [31:0] KB = 32'h95A4_F1E0;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [31:0] data;   // write data, expected read data, or idle cycles
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 50;
    localparam vec_t TBL [0:NV-1] = '{
        '{OP_RD, 8'h50, 32'h0,         8'd1},  // R1 status 0 after reset
        '{OP_WR, 8'h00, 32'h1111_1111, 8'd2},  // R2 locked write
        '{OP_RD, 8'h00, 32'h0,         8'd2},
        '{OP_WR, 8'h74, KB,            8'd5},  // R5 second key alone
        '{OP_ID, 8'h00, 32'd8,         8'd5},
        '{OP_RD, 8'h50, 32'h0,         8'd5},
        '{OP_WR, 8'h70, KA,            8'd3},  // R3 first key
        '{OP_WR, 8'h04, 32'h2222_2222, 8'd10}, // R10 write between keys
        '{OP_WR, 8'h74, KB,            8'd3},  // R3 second key
        '{OP_ID, 8'h00, 32'd3,         8'd4},
        '{OP_RD, 8'h50, 32'h0,         8'd4},  // R4 not yet
        '{OP_ID, 8'h00, 32'd1,         8'd4},
        '{OP_RD, 8'h50, 32'h0080_0000, 8'd3},  // R3/R4 open
        '{OP_RD, 8'h04, 32'h0,         8'd10}, // R10 dropped
        '{OP_WR, 8'h04, 32'h2222_2222, 8'd9},
        '{OP_RD, 8'h04, 32'h2222_2222, 8'd9},  // R9
        '{OP_WR, 8'h50, 32'hFFFF_FFFF, 8'd9},
        '{OP_RD, 8'h50, 32'hFFFF_FFFF, 8'd9},
        '{OP_RD, 8'h70, 32'h0,         8'd8},  // R8
        '{OP_RD, 8'h74, 32'h0,         8'd8},
        '{OP_WR, 8'h70, KA,            8'd7},  // R7 key again keeps open
        '{OP_RD, 8'h50, 32'hFFFF_FFFF, 8'd7},
        '{OP_WR, 8'h74, 32'h0,         8'd7},
        '{OP_RD, 8'h50, 32'hFFFF_FFFF, 8'd7},
        '{OP_WR, 8'h70, 32'h0,         8'd7},  // R7 relock
        '{OP_RD, 8'h50, 32'hFF7F_FFFF, 8'd7},
        '{OP_WR, 8'h04, 32'h3333_3333, 8'd2},
        '{OP_RD, 8'h04, 32'h2222_2222, 8'd2},
        '{OP_WR, 8'h70, KA,            8'd5},  // R5 wrong second kick
        '{OP_WR, 8'h74, 32'hDEAD_BEEF, 8'd5},
        '{OP_WR, 8'h74, KB,            8'd5},
        '{OP_ID, 8'h00, 32'd6,         8'd5},
        '{OP_RD, 8'h50, 32'hFF7F_FFFF, 8'd5},
        '{OP_WR, 8'h70, KA,            8'd6},  // R6 wrong first kick
        '{OP_WR, 8'h70, 32'h0000_1234, 8'd6},
        '{OP_WR, 8'h74, KB,            8'd6},
        '{OP_ID, 8'h00, 32'd6,         8'd6},
        '{OP_RD, 8'h50, 32'hFF7F_FFFF, 8'd6},
        '{OP_WR, 8'h70, KA,            8'd2},  // R2 write while settling
        '{OP_WR, 8'h74, KB,            8'd2},
        '{OP_WR, 8'h08, 32'h4444_4444, 8'd2},
        '{OP_ID, 8'h00, 32'd6,         8'd2},
        '{OP_RD, 8'h08, 32'h0,         8'd2},
        '{OP_RD, 8'h50, 32'hFFFF_FFFF, 8'd3},
        '{OP_WR, 8'h70, 32'h0,         8'd7},  // R7 relock while settling
        '{OP_WR, 8'h70, KA,            8'd7},
        '{OP_WR, 8'h74, KB,            8'd7},
        '{OP_WR, 8'h70, 32'h0,         8'd7},
        '{OP_ID, 8'h00, 32'd6,         8'd7},
        '{OP_RD, 8'h50, 32'hFF7F_FFFF, 8'd7}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        unlocked;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wprot_lock #(.ADDR_W(8), .NUM_PROT(4), .PROT_BASE(0), .UNLOCK_LAT(LAT)) i_wprot_lock (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .unlocked(unlocked)
    );

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_chk(input logic [7:0] a, input logic [31:0] exp, input int rq);
        addr = a;
        #1;
        checks++;
        if (rdata !== exp) begin
            fails++;
            $display("FAIL R%0d addr=%h actual=%h expected=%h", rq, a, rdata, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            case (TBL[i].op)
                OP_WR:   do_wr(TBL[i].addr, TBL[i].data);
                OP_RD:   do_chk(TBL[i].addr, TBL[i].data, int'(TBL[i].req));
                default: repeat (int'(TBL[i].data)) @(negedge clk);
            endcase
        end
        // R1: reset clears everything and locks again
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        do_chk(8'h50, 32'h0, 1);
        do_chk(8'h04, 32'h0, 1);
        checks++;
        if (unlocked !== 1'b0) begin
            fails++;
            $display("FAIL R1 unlocked actual=%b expected=0", unlocked);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule